// File: doc/BRIEF.md
# H-Bridge Current-Chopping Controller

This block is the digital core of a full-bridge motor driver. It turns a direction select, an external PWM gate and a decay-mode select into four gate-enable signals: a high-side and a low-side switch for each of the two bridge legs, A and B. It also runs an internal chopper. When the external current comparator reports that the winding current has reached its trip level, a source-enable latch clears. The bridge then falls into its decay pattern for a fixed number of oscillator clocks, and drive resumes after that.

Two supply monitors feed the block. A regulator fault removes all drive. A charge-pump fault removes only the high-side switches. Every output is registered. A leg that hands over from one switch to the other always passes through one clock with both of its switches off.

Top module: `hbridge_chopper`

## Requirements
- R1: With `phase_fwd`=1, `pwm_gate`=1 and the source latch set, the bridge settles to `a_hi`=1, `b_lo`=1, with `a_lo` and `b_hi` at 0.
- R2: With `phase_fwd`=0, `pwm_gate`=1 and the source latch set, the bridge settles to `b_hi`=1, `a_lo`=1, with `a_hi` and `b_lo` at 0.
- R3: In the off state, `decay_sel`=0 selects fast decay, and the bridge settles to the opposite diagonal of the one selected by `phase_fwd`.
- R4: In the off state, `decay_sel`=1 selects slow decay, and the bridge settles to `a_lo`=`b_lo`=1 with both high-side outputs at 0.
- R5: `trip_raw` passes through a two-flop synchronizer and then clears the source latch. A trip sampled at clock edge k shows on the outputs after edge k+3. The off state covers both `pwm_gate`=0 and a cleared latch.
- R6: The latch stays cleared for exactly OFF_CYCLES clocks (default 96) and is set again on the next edge. With drive and slow decay, `a_hi` is therefore low for OFF_CYCLES+1 cycles, the extra cycle being the hand-over gap. A trip that is held high keeps chopping.
- R7: A trip seen while the latch is cleared is ignored. It neither extends nor restarts the off-time.
- R8: `vreg_fault`=1 drives all four outputs to 0 one edge later, for as long as it is held.
- R9: `pump_fault`=1 drives `a_hi` and `b_hi` to 0 one edge later. The low-side outputs keep following the selected pattern.
- R10: The high-side and low-side outputs of one leg are never 1 together. A leg moving from one switch to the other spends one cycle with both switches at 0.
- R11: A synchronous active-high `rst` drives all outputs to 0, sets the source latch and clears the off-time count and the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_fwd | input | 1 | Direction: 1 selects A-high/B-low, 0 selects B-high/A-low |
| pwm_gate | input | 1 | External PWM: 1 requests drive, 0 requests decay |
| decay_sel | input | 1 | Off-state decay: 0 fast, 1 slow |
| trip_raw | input | 1 | Asynchronous current-trip comparator flag |
| vreg_fault | input | 1 | Regulator fault, disables all switches |
| pump_fault | input | 1 | Charge-pump fault, disables the high-side switches |
| a_hi | output | 1 | Leg A high-side enable |
| a_lo | output | 1 | Leg A low-side enable |
| b_hi | output | 1 | Leg B high-side enable |
| b_lo | output | 1 | Leg B low-side enable |

## Verification
The hardest case to reach is a second trip arriving in the middle of an off-time. It takes a trip pulse to be timed against the synchronizer delay, and the outputs must then be watched for nearly a hundred cycles to prove that the window was not stretched. The bench pulses the trip while driving forward with slow decay. It injects a second pulse thirty cycles into the low period of `a_hi` and measures the full length of that low period. A behavioural model that counts down the off-time also runs in step with the design. Every cycle is compared against it, both under directed patterns and under long random runs that mix trips, faults, direction reversals and decay changes.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

    typedef enum logic {
        DECAY_FAST = 1'b0,
        DECAY_SLOW = 1'b1
    } decay_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } leg_t;

    localparam int NUM_LEGS = 2;
    localparam int LEG_A    = 0;
    localparam int LEG_B    = 1;

    typedef leg_t [NUM_LEGS-1:0] bridge_t;

    // Width of a down-counter that must hold n-1.
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Diagonal that conducts for the given direction.
    function automatic bridge_t conduct_pattern(input logic fwd);
        bridge_t p;
        p = '0;
        if (fwd) begin
            p[LEG_A].hi = 1'b1;
            p[LEG_B].lo = 1'b1;
        end else begin
            p[LEG_B].hi = 1'b1;
            p[LEG_A].lo = 1'b1;
        end
        return p;
    endfunction

    // Recirculation path while drive is off.
    function automatic bridge_t decay_pattern(input logic fwd, input decay_e mode);
        bridge_t p;
        if (mode == DECAY_SLOW) begin
            p = '0;
            p[LEG_A].lo = 1'b1;
            p[LEG_B].lo = 1'b1;
        end else begin
            p = conduct_pattern(!fwd);
        end
        return p;
    endfunction

    // Supply-fault gating: the regulator removes everything, the pump only the high side.
    function automatic bridge_t fault_mask(input bridge_t p, input logic reg_f, input logic pump_f);
        bridge_t q;
        for (int i = 0; i < NUM_LEGS; i++) begin
            q[i].hi = p[i].hi & ~reg_f & ~pump_f;
            q[i].lo = p[i].lo & ~reg_f;
        end
        return q;
    endfunction

endpackage

// File: rtl/hbc_trip_sync.sv
module hbc_trip_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic trip_raw,
    output logic trip_sync
);
    logic [STAGES-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[STAGES-2:0], trip_raw};
        end
    end

    assign trip_sync = shreg[STAGES-1];
endmodule

// File: rtl/hbc_offtime.sv
module hbc_offtime #(
    parameter int OFF_CYCLES = 96,
    parameter int CNT_W      = hbc_pkg::cnt_width(OFF_CYCLES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trip_sync,
    output logic             src_latch,
    output logic [CNT_W-1:0] off_cnt
);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(OFF_CYCLES - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            src_latch <= 1'b1;
            off_cnt   <= '0;
        end else if (src_latch) begin
            if (trip_sync) begin
                src_latch <= 1'b0;
                off_cnt   <= LOAD_VAL;
            end
        end else if (off_cnt == '0) begin
            src_latch <= 1'b1;
        end else begin
            off_cnt <= off_cnt - 1'b1;
        end
    end
endmodule

// File: rtl/hbc_leg_guard.sv
module hbc_leg_guard
    import hbc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  leg_t want,
    output leg_t leg_q
);
    // A switch may close only once its partner has been open for an edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            leg_q <= '0;
        end else begin
            leg_q.hi <= want.hi & ~leg_q.lo;
            leg_q.lo <= want.lo & ~leg_q.hi;
        end
    end
endmodule

// File: rtl/hbridge_chopper.sv
module hbridge_chopper
    import hbc_pkg::*;
#(
    parameter int OFF_CYCLES  = 96,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic phase_fwd,
    input  logic pwm_gate,
    input  logic decay_sel,
    input  logic trip_raw,
    input  logic vreg_fault,
    input  logic pump_fault,
    output logic a_hi,
    output logic a_lo,
    output logic b_hi,
    output logic b_lo
);
    localparam int CNT_W = cnt_width(OFF_CYCLES);

    logic             trip_sync;
    logic             src_latch;
    logic [CNT_W-1:0] off_cnt;
    decay_e           mode;
    logic             conduct;
    bridge_t          raw_pat;
    bridge_t          want;
    bridge_t          bridge_q;

    hbc_trip_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .trip_raw  (trip_raw),
        .trip_sync (trip_sync)
    );

    hbc_offtime #(.OFF_CYCLES(OFF_CYCLES), .CNT_W(CNT_W)) u_offtime (
        .clk       (clk),
        .rst       (rst),
        .trip_sync (trip_sync),
        .src_latch (src_latch),
        .off_cnt   (off_cnt)
    );

    assign mode = decay_e'(decay_sel);

    always_comb begin
        conduct = pwm_gate & src_latch;
        raw_pat = conduct ? conduct_pattern(phase_fwd) : decay_pattern(phase_fwd, mode);
        want    = fault_mask(raw_pat, vreg_fault, pump_fault);
    end

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        hbc_leg_guard u_guard (
            .clk   (clk),
            .rst   (rst),
            .want  (want[g]),
            .leg_q (bridge_q[g])
        );
    end

    assign a_hi = bridge_q[LEG_A].hi;
    assign a_lo = bridge_q[LEG_A].lo;
    assign b_hi = bridge_q[LEG_B].hi;
    assign b_lo = bridge_q[LEG_B].lo;
endmodule

// File: rtl/hbc_checker.sv
module hbc_checker #(
    parameter int OFF_CYCLES = 96
) (
    input logic clk,
    input logic rst,
    input logic vreg_fault,
    input logic pump_fault,
    input logic trip_sync,
    input logic src_latch,
    input logic a_hi,
    input logic a_lo,
    input logic b_hi,
    input logic b_lo
);
    // Consecutive cleared-latch cycles before the current one.
    int unsigned run_q;

    always_ff @(posedge clk) begin
        if (rst) run_q <= 0;
        else if (!src_latch) run_q <= run_q + 1;
        else run_q <= 0;
    end

    assert_trip_clears_R5: assert property (@(posedge clk) disable iff (rst)
        src_latch && trip_sync |=> !src_latch);

    assert_offtime_cap_R6: assert property (@(posedge clk) disable iff (rst)
        !src_latch |-> run_q < OFF_CYCLES);

    assert_offtime_full_R6: assert property (@(posedge clk) disable iff (rst)
        src_latch && run_q != 0 |-> run_q == OFF_CYCLES);

    assert_trip_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        !src_latch && run_q < OFF_CYCLES - 1 |=> !src_latch);

    assert_vreg_off_R8: assert property (@(posedge clk) disable iff (rst)
        vreg_fault |=> !(a_hi || a_lo || b_hi || b_lo));

    assert_pump_off_R9: assert property (@(posedge clk) disable iff (rst)
        pump_fault |=> !(a_hi || b_hi));

    assert_leg_a_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(a_hi && a_lo));

    assert_leg_b_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(b_hi && b_lo));

    assert_gap_a_R10: assert property (@(posedge clk) disable iff (rst)
        (a_hi && !$past(a_hi)) |-> !$past(a_lo));

    assert_gap_b_R10: assert property (@(posedge clk) disable iff (rst)
        (b_lo && !$past(b_lo)) |-> !$past(b_hi));

    assert_reset_off_R11: assert property (@(posedge clk)
        rst |=> !(a_hi || a_lo || b_hi || b_lo));
endmodule

bind hbridge_chopper hbc_checker #(.OFF_CYCLES(OFF_CYCLES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .vreg_fault (vreg_fault),
    .pump_fault (pump_fault),
    .trip_sync  (trip_sync),
    .src_latch  (src_latch),
    .a_hi       (a_hi),
    .a_lo       (a_lo),
    .b_hi       (b_hi),
    .b_lo       (b_lo)
);

// File: tb/hbridge_chopper_tb.sv
`timescale 1ns/1ps
module hbridge_chopper_tb;
    localparam int OFF_CYCLES = 96;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic phase_fwd = 1'b0, pwm_gate = 1'b0, decay_sel = 1'b0, trip_raw = 1'b0;
    logic vreg_fault = 1'b0, pump_fault = 1'b0;
    logic a_hi, a_lo, b_hi, b_lo;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string cur_req = "R11";

    hbridge_chopper #(.OFF_CYCLES(OFF_CYCLES)) u_dut (
        .clk(clk), .rst(rst), .phase_fwd(phase_fwd), .pwm_gate(pwm_gate),
        .decay_sel(decay_sel), .trip_raw(trip_raw), .vreg_fault(vreg_fault),
        .pump_fault(pump_fault), .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo)
    );

    always #2.5 clk = ~clk;

    // Behavioural reference: outputs, trip delay line, off-time remaining.
    bit m_ah, m_al, m_bh, m_bl;
    bit m_latch = 1'b1;
    bit m_s1, m_s2;
    int m_rem = 0;

    always @(posedge clk) begin : ref_model
        bit on, w_ah, w_al, w_bh, w_bl, n_ah, n_al, n_bh, n_bl;
        if (rst) begin
            m_ah = 0; m_al = 0; m_bh = 0; m_bl = 0;
            m_latch = 1; m_s1 = 0; m_s2 = 0; m_rem = 0;
        end else begin
            on = pwm_gate && m_latch;
            if (on) begin
                w_ah = phase_fwd;  w_bl = phase_fwd;
                w_bh = !phase_fwd; w_al = !phase_fwd;
            end else if (decay_sel) begin
                w_ah = 0; w_bh = 0; w_al = 1; w_bl = 1;
            end else begin
                w_ah = !phase_fwd; w_bl = !phase_fwd;
                w_bh = phase_fwd;  w_al = phase_fwd;
            end
            if (vreg_fault || pump_fault) begin w_ah = 0; w_bh = 0; end
            if (vreg_fault) begin w_al = 0; w_bl = 0; end
            n_ah = w_ah && !m_al; n_al = w_al && !m_ah;
            n_bh = w_bh && !m_bl; n_bl = w_bl && !m_bh;
            m_ah = n_ah; m_al = n_al; m_bh = n_bh; m_bl = n_bl;
            if (m_latch) begin
                if (m_s2) begin m_latch = 0; m_rem = OFF_CYCLES; end
            end else begin
                m_rem = m_rem - 1;
                if (m_rem == 0) m_latch = 1;
            end
            m_s2 = m_s1;
            m_s1 = trip_raw;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if ({a_hi, a_lo, b_hi, b_lo} !== {m_ah, m_al, m_bh, m_bl}) begin
                errors++;
                $display("FAIL %s model compare: actual %b expected %b", cur_req,
                         {a_hi, a_lo, b_hi, b_lo}, {m_ah, m_al, m_bh, m_bl});
            end
            if ((a_hi && a_lo) || (b_hi && b_lo)) begin
                errors++;
                $display("FAIL R10 leg overlap: actual %b expected no hi+lo pair",
                         {a_hi, a_lo, b_hi, b_lo});
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic go(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Output order in the vector: {a_hi, a_lo, b_hi, b_lo}.
    task automatic chk(input string req, input logic [3:0] exp);
        checks++;
        if ({a_hi, a_lo, b_hi, b_lo} !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, {a_hi, a_lo, b_hi, b_lo}, exp);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        int n;
        go(3);
        chk("R11 reset state", 4'b0000);
        rst = 0;

        cur_req = "R1";
        phase_fwd = 1; pwm_gate = 1; decay_sel = 0;
        go(5); chk("R1 forward drive", 4'b1001);

        cur_req = "R10";
        phase_fwd = 0;
        go(1); chk("R10 reversal gap", 4'b0000);
        cur_req = "R2";
        go(1); chk("R2 reverse drive", 4'b0110);
        go(5);

        cur_req = "R3";
        pwm_gate = 0; decay_sel = 0;
        go(3); chk("R3 fast decay reverse", 4'b1001);
        phase_fwd = 1;
        go(3); chk("R3 fast decay forward", 4'b0110);

        cur_req = "R4";
        decay_sel = 1;
        go(3); chk("R4 slow decay", 4'b0101);

        cur_req = "R5";
        phase_fwd = 1; pwm_gate = 1; decay_sel = 1;
        go(5); chk("R5 drive before trip", 4'b1001);
        trip_raw = 1; go(1); trip_raw = 0;
        go(2); chk("R5 still driving after edge k+2", 4'b1001);
        go(1); chk("R5 off after edge k+3", 4'b0001);
        cur_req = "R6";
        n = 0;
        while (!a_hi && n < 1000) begin n++; go(1); end
        chk_int("R6 a_hi low cycles (off-time plus gap)", n, OFF_CYCLES + 1);

        cur_req = "R7";
        go(5);
        trip_raw = 1; go(1); trip_raw = 0;
        go(3);
        n = 0;
        while (!a_hi && n < 1000) begin
            trip_raw = (n == 30);
            n++; go(1);
        end
        trip_raw = 0;
        chk_int("R7 retrip ignored, low cycles", n, OFF_CYCLES + 1);

        cur_req = "R6";
        go(5);
        trip_raw = 1; go(400); trip_raw = 0; go(120);

        cur_req = "R8";
        phase_fwd = 1; pwm_gate = 1;
        go(3); chk("R8 drive before fault", 4'b1001);
        vreg_fault = 1;
        go(1); chk("R8 all off", 4'b0000);
        go(3); chk("R8 held off", 4'b0000);
        vreg_fault = 0; go(5);

        cur_req = "R9";
        pump_fault = 1;
        go(1); chk("R9 high side off in drive", 4'b0001);
        pwm_gate = 0; decay_sel = 1;
        go(3); chk("R9 low side follows slow decay", 4'b0101);
        pump_fault = 0; go(5);

        cur_req = "R10";
        for (int i = 0; i < 3000; i++) begin
            phase_fwd  = ($urandom_range(0, 15) == 0) ? ~phase_fwd : phase_fwd;
            pwm_gate   = ($urandom_range(0, 3) != 0);
            decay_sel  = ($urandom_range(0, 31) == 0) ? ~decay_sel : decay_sel;
            trip_raw   = ($urandom_range(0, 19) == 0);
            vreg_fault = ($urandom_range(0, 99) == 0);
            pump_fault = ($urandom_range(0, 59) == 0);
            go(1);
        end
        trip_raw = 0; vreg_fault = 0; pump_fault = 0;

        cur_req = "R11";
        rst = 1;
        go(1); chk("R11 mid-run reset", 4'b0000);
        rst = 0;
        go(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule